// File: doc/BRIEF.md
# Round-Robin PCI Bus Arbiter

This block decides which initiator may drive a shared PCI bus. Six agents compete: one on-chip master and five external masters. Each external master has its own active-low request input and active-low grant output. The on-chip master uses an active-high request and grant. The priority rotates, so the agent granted most recently falls to the bottom of the order. This way every requester is served within a bounded number of turns.

The arbiter moves a grant only when it is safe to do so. A move happens either while the bus is idle (both FRAME# and IRDY# high) or once the current owner has withdrawn its request. Every move passes through at least one cycle in which no agent holds a grant. When no agent is requesting, the grant parks on the on-chip master. An enable input selects bypass mode, which lets a separate arbiter control the bus, for example when more than five external masters are fitted. In bypass mode every external grant output stays high and the on-chip request is returned directly as the on-chip grant.

Top module: `pci_rr_arbiter`

## Requirements
- R1: While reset is held with the arbiter enabled, no grant is asserted. On the first clock edge after reset release with no requests, the on-chip grant `int_gnt` goes high.
- R2: With the arbiter enabled, at most one of the six grants is asserted in any cycle.
- R3: A grant never moves directly from one agent to another. At least one cycle with no grant asserted lies between the two.
- R4: Agents are numbered 0 (on-chip) and 1..5 (external line `req_n[k]`/`gnt_n[k]` is agent k+1). The next grant goes to the first requester after the last granted agent in ascending order, wrapping from 5 back to 0. With all six requesting, grants cycle 2,3,4,5,0,1 starting from owner 1.
- R5: While the bus is busy (FRAME# or IRDY# low) and the owner keeps requesting, the grant stays unchanged.
- R6: With no request pending, the grant moves to the on-chip master and stays there.
- R7: When `arb_en` is low, all `gnt_n` bits are 1 and `int_gnt` equals `int_req` in the same cycle, independent of `req_n`.
- R8: Requests and grants on the external lines are active low: `req_n[k]`=0 requests, `gnt_n[k]`=0 grants.
- R9: From a cycle with no grant and at least one request, the next clock edge grants an agent that was requesting in that cycle.
- R10: When `arb_en` rises, arbitration resumes from a no-grant state. The first enabled edge grants the round-robin winner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_en | input | 1 | 1 = internal arbitration, 0 = bypass to an outside arbiter |
| req_n | input | N_EXT | External requests, active low |
| int_req | input | 1 | On-chip master request, active high |
| frame_n | input | 1 | FRAME# for bus-idle detection |
| irdy_n | input | 1 | IRDY# for bus-idle detection |
| gnt_n | output | N_EXT | External grants, active low |
| int_gnt | output | 1 | On-chip master grant, active high |

## Verification
The hardest situation to reach from the ports is a pending handoff held back by a busy bus. The stimulus first grants one external master. It then pulls FRAME# low and raises a competing request. The grant must stay put for several cycles, and it moves only after the owner drops its request, going through an empty cycle. A second hard case is the wrap of the rotating pointer past agent 5 back to the on-chip master. The bench reaches it by keeping all six agents requesting on an idle bus for a full rotation, and then by running a sparse pattern that skips several agents.

// File: rtl/pci_rr_arb_pkg.sv
package pci_rr_arb_pkg;
  localparam int MAX_AGENTS = 32;

  // First requesting agent after 'last' in ascending, wrapping order.
  // Returns 0 (on-chip master) when nobody requests.
  function automatic int rr_pick(input logic [MAX_AGENTS-1:0] r,
                                 input int last, input int n);
    int idx;
    rr_pick = 0;
    for (int k = MAX_AGENTS; k >= 1; k--) begin
      if (k <= n) begin
        idx = last + k;
        if (idx >= n) idx = idx - n;
        if (r[idx]) rr_pick = idx;
      end
    end
  endfunction
endpackage

// File: rtl/pci_arb_picker.sv
module pci_arb_picker #(
  parameter int N_AGT = 6,
  localparam int IW = $clog2(N_AGT)
) (
  input  logic [N_AGT-1:0] req,
  input  logic [IW-1:0]    last,
  output logic [IW-1:0]    win,
  output logic             win_valid
);
  import pci_rr_arb_pkg::*;
  logic [MAX_AGENTS-1:0] req_wide;

  always_comb begin
    req_wide = '0;
    req_wide[N_AGT-1:0] = req;
    win       = IW'(rr_pick(req_wide, int'(last), N_AGT));
    win_valid = |req;
  end
endmodule

// File: rtl/pci_arb_grant_ctl.sv
module pci_arb_grant_ctl #(
  parameter int N_AGT = 6,
  localparam int IW = $clog2(N_AGT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [N_AGT-1:0] req,
  input  logic             bus_idle,
  input  logic [IW-1:0]    win,
  input  logic             win_valid,
  output logic [N_AGT-1:0] grant,
  output logic [IW-1:0]    last
);
  logic [N_AGT-1:0] grant_q;
  logic [IW-1:0]    last_q;
  logic [N_AGT-1:0] win_oh;
  logic held, owner_req, may_switch, keep_owner;

  assign win_oh     = N_AGT'(1) << win;
  assign held       = |grant_q;
  assign owner_req  = |(grant_q & req);
  assign may_switch = bus_idle | ~owner_req;
  assign keep_owner = (grant_q == win_oh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      last_q  <= IW'(N_AGT - 1);
    end else if (!en) begin
      grant_q <= '0;
    end else if (!held) begin
      grant_q <= win_oh;
      if (win_valid) last_q <= win;
    end else if (may_switch && !keep_owner) begin
      grant_q <= '0;
    end
  end

  assign grant = grant_q;
  assign last  = last_q;
endmodule

// File: rtl/pci_arb_pinmux.sv
module pci_arb_pinmux #(
  parameter int N_EXT = 5
) (
  input  logic           en,
  input  logic [N_EXT:0] grant,
  input  logic           int_req,
  output logic [N_EXT-1:0] gnt_n,
  output logic           int_gnt
);
  for (genvar k = 0; k < N_EXT; k++) begin : g_ext
    assign gnt_n[k] = ~(en & grant[k+1]);
  end
  assign int_gnt = en ? grant[0] : int_req;
endmodule

// File: rtl/pci_rr_arbiter.sv
module pci_rr_arbiter #(
  parameter int N_EXT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arb_en,
  input  logic [N_EXT-1:0] req_n,
  input  logic             int_req,
  input  logic             frame_n,
  input  logic             irdy_n,
  output logic [N_EXT-1:0] gnt_n,
  output logic             int_gnt
);
  localparam int N_AGT = N_EXT + 1;
  localparam int IW    = $clog2(N_AGT);

  logic [N_AGT-1:0] req_vec;
  logic [N_AGT-1:0] grant_vec;
  logic [IW-1:0]    last_idx;
  logic [IW-1:0]    win_idx;
  logic             win_valid;
  logic             bus_idle;

  assign req_vec  = {~req_n, int_req};
  assign bus_idle = frame_n & irdy_n;

  pci_arb_picker #(.N_AGT(N_AGT)) i_picker (
    .req(req_vec), .last(last_idx), .win(win_idx), .win_valid(win_valid)
  );

  pci_arb_grant_ctl #(.N_AGT(N_AGT)) i_ctl (
    .clk(clk), .rst_n(rst_n), .en(arb_en), .req(req_vec), .bus_idle(bus_idle),
    .win(win_idx), .win_valid(win_valid), .grant(grant_vec), .last(last_idx)
  );

  pci_arb_pinmux #(.N_EXT(N_EXT)) i_pins (
    .en(arb_en), .grant(grant_vec), .int_req(int_req),
    .gnt_n(gnt_n), .int_gnt(int_gnt)
  );
endmodule

// File: rtl/pci_rr_arbiter_chk.sv
module pci_rr_arbiter_chk #(
  parameter int N_EXT = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arb_en,
  input logic [N_EXT-1:0] req_n,
  input logic             int_req,
  input logic             frame_n,
  input logic             irdy_n,
  input logic [N_EXT-1:0] gnt_n,
  input logic             int_gnt
);
  logic [N_EXT:0] gv;
  logic [N_EXT:0] rv;
  logic           busy;
  logic           armed = 1'b0;

  assign gv   = {~gnt_n, int_gnt};
  assign rv   = {~req_n, int_req};
  assign busy = ~(frame_n & irdy_n);

  always_ff @(posedge clk) armed <= 1'b1;

  assert_rst_quiet_R1: assert property (@(posedge clk)
    (armed && !rst_n && arb_en) |-> (gv == '0));

  assert_one_grant_R2: assert property (@(posedge clk)
    disable iff (!rst_n || !arb_en) $onehot0(gv));

  assert_gap_R3: assert property (@(posedge clk)
    disable iff (!rst_n || !arb_en)
    (gv != '0) |=> (gv == '0 || gv == $past(gv)));

  assert_busy_hold_R5: assert property (@(posedge clk)
    disable iff (!rst_n || !arb_en)
    (busy && (gv & rv) != '0) |=> $stable(gv));

  assert_park_R6: assert property (@(posedge clk)
    disable iff (!rst_n || !arb_en)
    (gv == (N_EXT+1)'(1) && rv == '0) |=> (gv == (N_EXT+1)'(1)));

  assert_bypass_R7: assert property (@(posedge clk)
    (armed && !arb_en) |-> (gnt_n == '1 && int_gnt == int_req));

  assert_fill_R9: assert property (@(posedge clk)
    disable iff (!rst_n || !arb_en)
    (gv == '0 && rv != '0) |=> ((gv & $past(rv)) != '0));
endmodule

bind pci_rr_arbiter pci_rr_arbiter_chk #(.N_EXT(N_EXT)) i_chk (
  .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .req_n(req_n), .int_req(int_req),
  .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_n), .int_gnt(int_gnt)
);

// File: tb/test_pci_rr_arbiter.sv
module test_pci_rr_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arb_en = 1'b1;
  logic [4:0] req_n = 5'h1f;
  logic       int_req = 1'b0;
  logic       frame_n = 1'b1;
  logic       irdy_n = 1'b1;
  logic [4:0] gnt_n;
  logic       int_gnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pci_rr_arbiter #(.N_EXT(5)) i_pci_rr_arbiter (
    .clk(clk), .rst_n(rst_n), .arb_en(arb_en), .req_n(req_n), .int_req(int_req),
    .frame_n(frame_n), .irdy_n(irdy_n), .gnt_n(gnt_n), .int_gnt(int_gnt)
  );

  // Expected {gnt_n, int_gnt} with agent a owning the bus; a < 0 means none.
  function automatic logic [5:0] own(input int a);
    logic [5:0] v;
    v = 6'b111110;
    if (a == 0) v[0] = 1'b1;
    else if (a > 0) v[a] = 1'b0;
    return v;
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [5:0] exp);
    logic [5:0] act;
    act = {gnt_n, int_gnt};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    #2;
    chk("R1 grants quiet in reset", own(-1));
    tick();
    chk("R1 still quiet", own(-1));
    rst_n = 1'b1;
    tick();
    chk("R1 R6 park on-chip after reset", own(0));
  endtask

  task automatic t_first_external();
    req_n = 5'b11011;             // agent 3 requests (R8)
    tick();
    chk("R3 gap before handoff", own(-1));
    tick();
    chk("R8 R9 external line 2 granted low", own(3));
  endtask

  task automatic t_busy_hold();
    frame_n = 1'b0;
    req_n = 5'b11010;             // agents 1 and 3
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R5 owner kept while bus busy", own(3));
    end
    req_n = 5'b11110;             // owner 3 withdraws, bus still busy
    tick();
    chk("R3 gap after owner drop", own(-1));
    tick();
    chk("R5 next requester after drop", own(1));
    frame_n = 1'b1;
  endtask

  task automatic t_rotation();
    int order[6] = '{2, 3, 4, 5, 0, 1};
    int_req = 1'b1;
    req_n = 5'b00000;
    foreach (order[i]) begin
      tick();
      chk("R3 gap in rotation", own(-1));
      tick();
      chk("R4 R2 rotation order", own(order[i]));
      n_chk++;
      if ($countones({~gnt_n, int_gnt}) > 1) begin
        n_bad++;
        $display("FAIL R2: grants %b expected at most one", {~gnt_n, int_gnt});
      end
    end
  endtask

  task automatic t_sparse();
    int order[3] = '{4, 0, 4};
    int_req = 1'b1;
    req_n = 5'b10111;             // agents 0 and 4
    foreach (order[i]) begin
      tick();
      chk("R3 gap sparse", own(-1));
      tick();
      chk("R4 skip and wrap", own(order[i]));
    end
  endtask

  task automatic t_park();
    int_req = 1'b0;
    req_n = 5'h1f;
    tick();
    chk("R3 gap before parking", own(-1));
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R6 parked on-chip", own(0));
    end
  endtask

  task automatic t_bypass();
    arb_en = 1'b0;
    #1;
    chk("R7 bypass idle", 6'b111110);
    int_req = 1'b1;
    req_n = 5'b00000;
    #1;
    chk("R7 bypass passes on-chip request", 6'b111111);
    tick();
    chk("R7 bypass ignores external requests", 6'b111111);
    int_req = 1'b0;
    #1;
    chk("R7 bypass follows request low", 6'b111110);
    req_n = 5'b01111;             // only agent 5
    tick();
    arb_en = 1'b1;
    #1;
    chk("R10 empty at re-enable", own(-1));
    tick();
    chk("R10 first enabled edge grants winner", own(5));
  endtask

  initial begin
    t_reset();
    t_first_external();
    t_busy_hold();
    t_rotation();
    t_sparse();
    t_park();
    t_bypass();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule